// File: doc/BRIEF.md
# Serial DAC command front end

This block is the digital front end of a 10-bit voltage-output converter. A host writes 16-bit command words over a three-wire, write-only serial port made of an active-low select, a serial clock and a data line. The block brings those three asynchronous pins into its own fast system clock and assembles the frame. When the select line is released, it carries out the 3-bit command held in the frame.

Two code registers are kept: a staging register and the register that drives the converter. The commands can load the staging register alone, load both registers at once, copy staging to output, put the output into a low-power shutdown state, or do nothing. Shutdown keeps both stored codes. A later copy or load-both command wakes the output. After reset and after every wake-up, a settle flag stays low for a fixed time derived from the system clock rate.

Top module: `ser_dac_front`

## Requirements
- R1: After reset, `dac_code` is 0, `shutdown` is 0, `settled` is 0 and `subbit_warn` is 0.
- R2: A frame is 16 bits, sent MSB first, with bits [15:13] = command, [12:3] = code and [2:0] = sub-bits. Commands 000 and 100 write the code into both registers, so `dac_code` takes the code, and they clear `shutdown`.
- R3: Commands 001 and 101 write the code into the staging register only. `dac_code` keeps its value.
- R4: Commands 010 and 110 copy the staging register to `dac_code` and clear `shutdown`.
- R5: Command 111 sets `shutdown` and forces `settled` low. While `shutdown` is set, `dac_code` is held and frames are still accepted: a staging load does not change the output or wake it.
- R6: Command 011 changes nothing. For the 111, 011 and x10 commands the code field has no effect.
- R7: A frame that ends, when the select line rises, with any bit count other than exactly 16 is discarded. Registers and shutdown state stay unchanged.
- R8: A frame split into two 8-bit bursts, with the select line held low between them, acts exactly like one 16-bit burst.
- R9: Serial clock edges that occur while the select line is high are not counted and do not shift data.
- R10: `settled` rises SETTLE_US microseconds (CLK_MHZ*SETTLE_US system cycles) after reset is released, and again after each wake from shutdown. It is low during that interval.
- R11: A valid frame with nonzero sub-bits still executes normally. It also sets `subbit_warn`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, data sampled on its rising edge |
| din | input | 1 | Serial data in |
| dac_code | output | 10 | Code driving the converter |
| shutdown | output | 1 | Output and reference are in the high-impedance state |
| settled | output | 1 | Output has had time to settle |
| subbit_warn | output | 1 | Sticky flag: a frame arrived with nonzero sub-bits |

## Verification
A miscount in the frame receiver shows up within one frame. Either a good frame leaves `dac_code` unchanged, or a short or long frame writes a code. A staging register that has gone wrong stays hidden until a copy command exposes it on `dac_code`, so the bench always follows a staging load with a copy. A settle timer that fails to restart is only visible about 20 µs after a wake, as `settled` being high too early or low too late. The bench therefore samples just inside and just outside that window.

// File: rtl/ser_dac_pkg.sv
package ser_dac_pkg;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_LOAD_BOTH,
    ACT_LOAD_STAGE,
    ACT_COPY,
    ACT_SLEEP
  } act_e;

  // Command decode: priority matters because 111 and 011 overlap the x11 group
  function automatic act_e decode_cmd(input logic [2:0] cmd);
    act_e a;
    if (cmd == 3'b111)           a = ACT_SLEEP;
    else if (cmd == 3'b011)      a = ACT_NONE;
    else if (cmd[1:0] == 2'b10)  a = ACT_COPY;
    else if (cmd[1:0] == 2'b01)  a = ACT_LOAD_STAGE;
    else                         a = ACT_LOAD_BOTH;
    return a;
  endfunction

endpackage

// File: rtl/ser_dac_sync.sv
module ser_dac_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= async_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/ser_dac_rx.sv
module ser_dac_rx #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n_s,
  input  logic               sclk_s,
  input  logic               din_s,
  output logic               frame_stb,
  output logic [FRAME_W-1:0] frame_word
);

  localparam int CNT_W = $clog2(FRAME_W) + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic               sclk_q, cs_q;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shreg;
  logic               sclk_rise, cs_rise;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign cs_rise   = cs_n_s & ~cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      bit_cnt    <= '0;
      shreg      <= '0;
      frame_stb  <= 1'b0;
      frame_word <= '0;
    end else begin
      sclk_q    <= sclk_s;
      cs_q      <= cs_n_s;
      frame_stb <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[FRAME_W-2:0], din_s};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      end
      if (cs_rise && bit_cnt == CNT_FULL) begin
        frame_stb  <= 1'b1;
        frame_word <= shreg;
      end
    end
  end

endmodule

// File: rtl/ser_dac_core.sv
module ser_dac_core
  import ser_dac_pkg::*;
#(
  parameter int CMD_W  = 3,
  parameter int CODE_W = 10,
  parameter int SUB_W  = 3,
  localparam int FRAME_W = CMD_W + CODE_W + SUB_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_stb,
  input  logic [FRAME_W-1:0] frame_word,
  output logic [CODE_W-1:0]  dac_code,
  output logic               shutdown,
  output logic               warn,
  output logic               wake
);

  logic [CMD_W-1:0]  cmd;
  logic [CODE_W-1:0] code;
  logic [SUB_W-1:0]  sub;
  logic [CODE_W-1:0] stage_q;
  act_e              act;

  assign cmd  = frame_word[FRAME_W-1 -: CMD_W];
  assign code = frame_word[SUB_W +: CODE_W];
  assign sub  = frame_word[SUB_W-1:0];
  assign act  = decode_cmd(cmd[2:0]);

  // Wake is combinational so the settle timer restarts on the same edge
  assign wake = frame_stb && shutdown &&
                (act == ACT_COPY || act == ACT_LOAD_BOTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= '0;
      dac_code <= '0;
      shutdown <= 1'b0;
      warn     <= 1'b0;
    end else if (frame_stb) begin
      if (sub != '0) warn <= 1'b1;
      unique case (act)
        ACT_LOAD_BOTH: begin
          stage_q  <= code;
          dac_code <= code;
          shutdown <= 1'b0;
        end
        ACT_LOAD_STAGE: stage_q <= code;
        ACT_COPY: begin
          dac_code <= stage_q;
          shutdown <= 1'b0;
        end
        ACT_SLEEP: shutdown <= 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ser_dac_settle.sv
module ser_dac_settle #(
  parameter int CYCLES = 5000,
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic done
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == LAST) done <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ser_dac_front.sv
module ser_dac_front #(
  parameter int CODE_W      = 10,
  parameter int CMD_W       = 3,
  parameter int SUB_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int CLK_MHZ     = 250,
  parameter int SETTLE_US   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic [CODE_W-1:0] dac_code,
  output logic              shutdown,
  output logic              settled,
  output logic              subbit_warn
);

  localparam int FRAME_W       = CMD_W + CODE_W + SUB_W;
  localparam int SETTLE_CYCLES = CLK_MHZ * SETTLE_US;

  logic [2:0]         pins_s;
  logic               frame_stb;
  logic [FRAME_W-1:0] frame_word;
  logic               wake, settle_done;

  ser_dac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .async_i({cs_n, sclk, din}), .sync_o(pins_s)
  );

  ser_dac_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst(rst),
    .cs_n_s(pins_s[2]), .sclk_s(pins_s[1]), .din_s(pins_s[0]),
    .frame_stb(frame_stb), .frame_word(frame_word)
  );

  ser_dac_core #(.CMD_W(CMD_W), .CODE_W(CODE_W), .SUB_W(SUB_W)) u_core (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .frame_word(frame_word),
    .dac_code(dac_code), .shutdown(shutdown), .warn(subbit_warn), .wake(wake)
  );

  ser_dac_settle #(.CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst(rst), .restart(wake), .done(settle_done)
  );

  assign settled = settle_done & ~shutdown;

endmodule

// File: rtl/ser_dac_front_chk.sv
module ser_dac_front_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_stb,
  input logic [CODE_W-1:0] dac_code,
  input logic              shutdown,
  input logic              settled,
  input logic              subbit_warn
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && !shutdown && !settled && !subbit_warn));

  a_r5_hold_in_shutdown: assert property (@(posedge clk) disable iff (rst)
    (shutdown && $past(shutdown)) |-> $stable(dac_code));

  a_r7_code_moves_only_on_frame: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_code) |-> $past(frame_stb));

  a_r10_wake_restarts_settle: assert property (@(posedge clk) disable iff (rst)
    $fell(shutdown) |-> !settled);

  a_r11_warn_sticky: assert property (@(posedge clk) disable iff (rst)
    subbit_warn |=> subbit_warn);

endmodule

bind ser_dac_front ser_dac_front_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .frame_stb(frame_stb), .dac_code(dac_code),
  .shutdown(shutdown), .settled(settled), .subbit_warn(subbit_warn)
);

// File: tb/ser_dac_front_tb.sv
module ser_dac_front_tb;

  localparam int SETTLE = 250 * 20;
  localparam int HALF   = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       din = 1'b0;
  logic [9:0] dac_code;
  logic       shutdown, settled, subbit_warn;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ser_dac_front u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dac_code(dac_code), .shutdown(shutdown), .settled(settled),
    .subbit_warn(subbit_warn)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [2:0] c, input logic [9:0] d,
                                     input logic [2:0] s);
    return {c, d, s};
  endfunction

  task automatic send_raw(input logic [31:0] bits, input int n, input bit split);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      if (split && i == n - 9) wait_clk(60);
      din = bits[i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic send(input logic [15:0] w);
    send_raw({16'b0, w}, 16, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 code", dac_code, 0);
    chk("R1 shutdown", shutdown, 0);
    chk("R1 settled", settled, 0);
    chk("R1 warn", subbit_warn, 0);
    wait_clk(SETTLE - 40);
    chk("R10 settled low before window", settled, 0);
    wait_clk(80);
    chk("R10 settled high after window", settled, 1);
  endtask

  task automatic t_load_both;
    send(mk(3'b000, 10'h2A5, 3'b000));
    chk("R2 cmd000", dac_code, 'h2A5);
    send(mk(3'b100, 10'h13C, 3'b000));
    chk("R2 cmd100", dac_code, 'h13C);
    chk("R2 shutdown clear", shutdown, 0);
  endtask

  task automatic t_stage_copy;
    send(mk(3'b001, 10'h3FF, 3'b000));
    chk("R3 cmd001 output unchanged", dac_code, 'h13C);
    send(mk(3'b010, 10'h000, 3'b000));
    chk("R4 cmd010 copy", dac_code, 'h3FF);
    send(mk(3'b101, 10'h055, 3'b000));
    chk("R3 cmd101 output unchanged", dac_code, 'h3FF);
    send(mk(3'b110, 10'h2EE, 3'b000));
    chk("R4 cmd110 copy", dac_code, 'h055);
  endtask

  task automatic t_shutdown;
    send(mk(3'b111, 10'h123, 3'b000));
    chk("R5 shutdown set", shutdown, 1);
    chk("R5 code held", dac_code, 'h055);
    chk("R5 settled low", settled, 0);
    send(mk(3'b001, 10'h200, 3'b000));
    chk("R5 stage load keeps shutdown", shutdown, 1);
    chk("R5 stage load keeps code", dac_code, 'h055);
    send(mk(3'b010, 10'h000, 3'b000));
    chk("R4 wake shutdown", shutdown, 0);
    chk("R4 wake restores stage", dac_code, 'h200);
    wait_clk(SETTLE - 60);
    chk("R10 settled low after wake", settled, 0);
    wait_clk(80);
    chk("R10 settled high after wake", settled, 1);
  endtask

  task automatic t_nop;
    send(mk(3'b011, 10'h3AA, 3'b000));
    chk("R6 nop code", dac_code, 'h200);
    chk("R6 nop shutdown", shutdown, 0);
    chk("R6 nop settled", settled, 1);
    send(mk(3'b010, 10'h111, 3'b000));
    chk("R6 copy ignores data", dac_code, 'h200);
  endtask

  task automatic t_bad_len;
    send_raw({17'b0, mk(3'b000, 10'h0F0, 3'b000) >> 1}, 15, 1'b0);
    chk("R7 15-bit frame dropped", dac_code, 'h200);
    send_raw({15'b0, mk(3'b000, 10'h0F0, 3'b000), 1'b0}, 17, 1'b0);
    chk("R7 17-bit frame dropped", dac_code, 'h200);
    send_raw({15'b0, mk(3'b111, 10'h0, 3'b0), 1'b0}, 17, 1'b0);
    chk("R7 bad frame no shutdown", shutdown, 0);
  endtask

  task automatic t_split;
    send_raw({16'b0, mk(3'b000, 10'h18C, 3'b000)}, 16, 1'b1);
    chk("R8 two bursts", dac_code, 'h18C);
  endtask

  task automatic t_cs_high;
    for (int i = 0; i < 5; i++) begin
      din = 1'b1;
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    chk("R9 edges with select high", dac_code, 'h18C);
    send(mk(3'b000, 10'h0C3, 3'b000));
    chk("R9 next frame counts 16", dac_code, 'h0C3);
  endtask

  task automatic t_subbits;
    chk("R11 warn clear", subbit_warn, 0);
    send(mk(3'b000, 10'h321, 3'b101));
    chk("R11 frame executes", dac_code, 'h321);
    chk("R11 warn set", subbit_warn, 1);
    send(mk(3'b000, 10'h001, 3'b000));
    chk("R11 warn sticky", subbit_warn, 1);
    chk("R11 clean frame", dac_code, 'h001);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(1);
    t_reset();
    t_load_both();
    t_stage_copy();
    t_shutdown();
    t_nop();
    t_bad_len();
    t_split();
    t_cs_high();
    t_subbits();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule